// File: doc/BRIEF.md
# Dual-Loop Phase Comparator with Lock Qualifier

This block holds the digital comparison stage of a two-loop frequency synthesizer. Each loop (a high-band loop and a low-band loop) receives a reference pulse train and a divided oscillator pulse train, both synchronous to the reference-oscillator clock. The block compares their rising edges. It drives a pair of charge-pump control lines that encode drive-high, drive-low or high impedance. Within every comparison it measures the phase error in oscillator clocks, and from that error it decides whether the loop is locked.

A single monitor pin carries either the combined lock flag of both loops or any one of the four pulse trains, so the pin can be used to probe the loops. Each loop has a power-save input. While a loop is in power-save, its controls stay at high impedance and its detector stays cleared, and a powered-down loop counts as locked in the combined flag. A polarity input per loop swaps the drive direction to suit the sense of the oscillator and the filter.

Top module: `dual_pfd_lock`

## Requirements
- R1: While reset is held and after its release with no input edges, all four charge-pump lines are 0 and, with both loops powered and the monitor enable at 0, the monitor pin is 0 (no loop locked).
- R2: Encoding: a source line at 1 drives the pump output high, a sink line at 1 drives it low, and both at 0 leave it at high impedance. With the loop's polarity input at 0, a reference edge that comes before the oscillator edge raises the source line from the clock after the reference edge until the comparison ends. An oscillator edge that comes first raises the sink line instead.
- R3: With the polarity input at 1, the roles of the source and sink lines in R2 are swapped.
- R4: When the second edge of a comparison arrives, or when both edges arrive in the same clock, the source and sink lines are both 1 for exactly one clock and then both 0. This pulse also appears at zero phase error.
- R5: The phase error is the number of oscillator clocks from the first edge to the second. The loop's lock flag falls as soon as a pending error reaches the unlock threshold (default 3 clocks), in the clock after the count reaches that value, before the comparison completes.
- R6: A loop's lock flag rises only after three consecutive completed comparisons whose error is at most the lock threshold (default 2 clocks). A comparison with a larger error restarts the run.
- R7: With the monitor enable at 0, the monitor pin is 1 only when each loop is either locked or in power-save (power input at 0). It is 0 if a powered loop is unlocked.
- R8: With the monitor enable at 1, the 2-bit select picks the pin: 00 gives the low-band reference, 10 the high-band reference, 01 the low-band oscillator train and 11 the high-band oscillator train.
- R9: From the clock after a loop's power input goes to 0, its source and sink lines stay at 0, its lock flag is cleared and its detector flags are cleared. Edges seen during power-save leave no trace, so the first comparison after wake-up starts fresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fr_rf | input | 1 | High-band loop reference pulse train |
| fp_rf | input | 1 | High-band loop divided oscillator pulse train |
| fr_if | input | 1 | Low-band loop reference pulse train |
| fp_if | input | 1 | Low-band loop divided oscillator pulse train |
| pwr_rf | input | 1 | High-band loop active (0 = power-save) |
| pwr_if | input | 1 | Low-band loop active (0 = power-save) |
| pol_rf | input | 1 | High-band loop drive polarity |
| pol_if | input | 1 | Low-band loop drive polarity |
| mon_en | input | 1 | 1 = monitor a pulse train, 0 = combined lock flag |
| mon_sel | input | 2 | Pulse-train select, bit 1 = high band, bit 0 = oscillator train |
| cp_rf_src | output | 1 | High-band pump drive-high |
| cp_rf_sink | output | 1 | High-band pump drive-low |
| cp_if_src | output | 1 | Low-band pump drive-high |
| cp_if_sink | output | 1 | Low-band pump drive-low |
| mon_out | output | 1 | Shared monitor pin |

## Verification
A stale edge flag shows up at the pump lines one clock after the next edge. The wrong line is raised, or the end-of-comparison pulse comes early, and the bench samples at exactly that cycle. A wrong error count or lock run-length changes the monitor pin within the comparison that exposes it. An early unlock that is too late shows up while the comparison is still pending, and a premature lock shows up one comparison early. A power-save state that is not cleared shows up as the wrong drive direction on the first comparison after wake-up.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // {source, sink} for one loop from the pending leads and the closing pulse
  function automatic logic [1:0] cp_drive(input logic pol, input logic lead_r,
                                          input logic lead_v, input logic pulse);
    logic hi;
    logic lo;
    hi = pol ? lead_v : lead_r;
    lo = pol ? lead_r : lead_v;
    return {hi | pulse, lo | pulse};
  endfunction

  // a loop in power-save is treated as locked
  function automatic logic loop_ok(input logic lock, input logic pwr);
    return lock | ~pwr;
  endfunction

  // monitor pin: sel[1] picks the high-band loop, sel[0] picks the oscillator train
  function automatic logic mon_pick(input logic en, input logic [1:0] sel,
                                    input logic lock_all,
                                    input logic fr_lo, input logic fr_hi,
                                    input logic fp_lo, input logic fp_hi);
    logic r;
    case (sel)
      2'b00:   r = fr_lo;
      2'b10:   r = fr_hi;
      2'b01:   r = fp_lo;
      default: r = fp_hi;
    endcase
    return en ? r : lock_all;
  endfunction

endpackage

// File: rtl/pfd_phase_cmp.sv
module pfd_phase_cmp #(
  parameter int CNT_W = 6,
  parameter int TWU   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr,
  input  logic             fr,
  input  logic             fp,
  output logic             lead_r,
  output logic             lead_v,
  output logic             done,
  output logic             trip,
  output logic [CNT_W-1:0] err
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] TRIP = CNT_W'(TWU);

  logic fr_q, fp_q;
  logic ref_f, vco_f;
  logic [CNT_W-1:0] cnt;

  logic r_ev, v_ev, nr, nv, pend;
  logic [CNT_W-1:0] cnt_nx;

  assign r_ev   = fr & ~fr_q;
  assign v_ev   = fp & ~fp_q;
  assign nr     = ref_f | r_ev;
  assign nv     = vco_f | v_ev;
  assign done   = pwr & nr & nv;
  assign pend   = pwr & (nr ^ nv);
  assign cnt_nx = (cnt == CMAX) ? cnt : cnt + 1'b1;
  assign trip   = pend & (cnt_nx >= TRIP);
  assign err    = cnt;
  assign lead_r = pend & nr;
  assign lead_v = pend & nv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fr_q  <= 1'b0;
      fp_q  <= 1'b0;
      ref_f <= 1'b0;
      vco_f <= 1'b0;
      cnt   <= '0;
    end else begin
      fr_q <= fr;
      fp_q <= fp;
      if (!pwr || done) begin
        ref_f <= 1'b0;
        vco_f <= 1'b0;
        cnt   <= '0;
      end else if (pend) begin
        ref_f <= nr;
        vco_f <= nv;
        cnt   <= cnt_nx;
      end
    end
  end
endmodule

// File: rtl/pfd_lock_qual.sv
module pfd_lock_qual #(
  parameter int CNT_W    = 6,
  parameter int TWU      = 3,
  parameter int TWL      = 2,
  parameter int LOCK_RUN = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr,
  input  logic             done,
  input  logic             trip,
  input  logic [CNT_W-1:0] err,
  output logic             lock
);
  localparam int GW = $clog2(LOCK_RUN + 1);
  localparam logic [GW-1:0] RUN_FULL = GW'(LOCK_RUN);
  localparam logic [GW-1:0] RUN_LAST = GW'(LOCK_RUN - 1);

  logic [GW-1:0] good;
  logic good_hit, bad_hit;

  assign good_hit = done & (err <= CNT_W'(TWL));
  assign bad_hit  = done & (err >= CNT_W'(TWU));

  always_ff @(posedge clk) begin
    if (!rst_n || !pwr) begin
      lock <= 1'b0;
      good <= '0;
    end else if (trip || bad_hit) begin
      lock <= 1'b0;
      good <= '0;
    end else if (good_hit) begin
      if (good >= RUN_LAST) begin
        lock <= 1'b1;
        good <= RUN_FULL;
      end else begin
        good <= good + 1'b1;
      end
    end else if (done) begin
      good <= '0;
    end
  end
endmodule

// File: rtl/pfd_loop.sv
module pfd_loop
  import pfd_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int TWU      = 3,
  parameter int TWL      = 2,
  parameter int LOCK_RUN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr,
  input  logic pol,
  input  logic fr,
  input  logic fp,
  output logic src,
  output logic sink,
  output logic lock
);
  logic lead_r, lead_v, done, trip;
  logic [CNT_W-1:0] err;
  logic [1:0] drv;

  pfd_phase_cmp #(.CNT_W(CNT_W), .TWU(TWU)) u_cmp (
    .clk(clk), .rst_n(rst_n), .pwr(pwr), .fr(fr), .fp(fp),
    .lead_r(lead_r), .lead_v(lead_v), .done(done), .trip(trip), .err(err)
  );

  pfd_lock_qual #(.CNT_W(CNT_W), .TWU(TWU), .TWL(TWL), .LOCK_RUN(LOCK_RUN)) u_lq (
    .clk(clk), .rst_n(rst_n), .pwr(pwr), .done(done), .trip(trip), .err(err),
    .lock(lock)
  );

  assign drv = cp_drive(pol, lead_r, lead_v, done);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src  <= 1'b0;
      sink <= 1'b0;
    end else begin
      src  <= pwr & drv[1];
      sink <= pwr & drv[0];
    end
  end
endmodule

// File: rtl/dual_pfd_lock.sv
module dual_pfd_lock
  import pfd_pkg::*;
#(
  parameter int CNT_W    = 6,
  parameter int TWU      = 3,
  parameter int TWL      = 2,
  parameter int LOCK_RUN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fr_rf,
  input  logic       fp_rf,
  input  logic       fr_if,
  input  logic       fp_if,
  input  logic       pwr_rf,
  input  logic       pwr_if,
  input  logic       pol_rf,
  input  logic       pol_if,
  input  logic       mon_en,
  input  logic [1:0] mon_sel,
  output logic       cp_rf_src,
  output logic       cp_rf_sink,
  output logic       cp_if_src,
  output logic       cp_if_sink,
  output logic       mon_out
);
  localparam int NLOOP = 2;

  // index 0 = low band, index 1 = high band
  logic [NLOOP-1:0] fr_v, fp_v, pwr_v, pol_v, src_v, sink_v, lock_v, ok_v;
  logic lock_all;

  assign fr_v  = {fr_rf, fr_if};
  assign fp_v  = {fp_rf, fp_if};
  assign pwr_v = {pwr_rf, pwr_if};
  assign pol_v = {pol_rf, pol_if};

  for (genvar g = 0; g < NLOOP; g++) begin : g_loop
    pfd_loop #(.CNT_W(CNT_W), .TWU(TWU), .TWL(TWL), .LOCK_RUN(LOCK_RUN)) u_loop (
      .clk(clk), .rst_n(rst_n), .pwr(pwr_v[g]), .pol(pol_v[g]),
      .fr(fr_v[g]), .fp(fp_v[g]),
      .src(src_v[g]), .sink(sink_v[g]), .lock(lock_v[g])
    );
    assign ok_v[g] = loop_ok(lock_v[g], pwr_v[g]);
  end

  assign lock_all   = &ok_v;
  assign cp_rf_src  = src_v[1];
  assign cp_rf_sink = sink_v[1];
  assign cp_if_src  = src_v[0];
  assign cp_if_sink = sink_v[0];
  assign mon_out    = mon_pick(mon_en, mon_sel, lock_all, fr_if, fr_rf, fp_if, fp_rf);
endmodule

// File: rtl/pfd_loop_chk.sv
module pfd_loop_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr,
  input logic src,
  input logic sink,
  input logic lock,
  input logic trip,
  input logic done
);
  // R9
  ps_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr |=> (!src && !sink));

  // R9
  ps_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr |=> !lock);

  // R5
  early_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> !lock);

  // R6
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(done));

  // R4
  close_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (src && sink));

  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src && sink) |=> !(src && sink));
endmodule

bind pfd_loop pfd_loop_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr(pwr), .src(src), .sink(sink),
  .lock(lock), .trip(trip), .done(done)
);

// File: tb/dual_pfd_lock_test.sv
module dual_pfd_lock_test;
  localparam int TWU = 3;
  localparam int TWL = 2;
  localparam int RUN = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fr_rf = 0, fp_rf = 0, fr_if = 0, fp_if = 0;
  logic pwr_rf = 1, pwr_if = 1, pol_rf = 0, pol_if = 0;
  logic mon_en = 0;
  logic [1:0] mon_sel = 2'b00;
  logic cp_rf_src, cp_rf_sink, cp_if_src, cp_if_sink, mon_out;

  int n_run = 0, n_fail = 0;
  int lk_rf = 0, gd_rf = 0, lk_if = 0, gd_if = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dual_pfd_lock uut (
    .clk(clk), .rst_n(rst_n), .fr_rf(fr_rf), .fp_rf(fp_rf), .fr_if(fr_if), .fp_if(fp_if),
    .pwr_rf(pwr_rf), .pwr_if(pwr_if), .pol_rf(pol_rf), .pol_if(pol_if),
    .mon_en(mon_en), .mon_sel(mon_sel),
    .cp_rf_src(cp_rf_src), .cp_rf_sink(cp_rf_sink),
    .cp_if_src(cp_if_src), .cp_if_sink(cp_if_sink), .mon_out(mon_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int code(input bit rf);
    return rf ? {cp_rf_src, cp_rf_sink} : {cp_if_src, cp_if_sink};
  endfunction

  function automatic int exp_lock_all();
    return ((lk_rf != 0) || !pwr_rf) && ((lk_if != 0) || !pwr_if);
  endfunction

  task automatic set_in(input bit rf, input bit is_fp, input logic v);
    if (rf) begin if (is_fp) fp_rf = v; else fr_rf = v; end
    else    begin if (is_fp) fp_if = v; else fr_if = v; end
  endtask

  task automatic model(input bit rf, input int a);
    int lk, gd;
    lk = rf ? lk_rf : lk_if;
    gd = rf ? gd_rf : gd_if;
    if (a >= TWU) begin lk = 0; gd = 0; end
    else if (a <= TWL) begin gd++; if (gd >= RUN) begin lk = 1; gd = RUN; end end
    else gd = 0;
    if (rf) begin lk_rf = lk; gd_rf = gd; end else begin lk_if = lk; gd_if = gd; end
  endtask

  // one comparison; off > 0: reference edge leads by off clocks
  task automatic cmp(input bit rf, input int off);
    int a;
    bit lead_fp, pol;
    int exp_src;
    a = (off < 0) ? -off : off;
    lead_fp = (off < 0);
    pol = rf ? pol_rf : pol_if;
    @(negedge clk);
    set_in(rf, lead_fp, 1'b1);
    if (a == 0) set_in(rf, !lead_fp, 1'b1);
    for (int i = 1; i <= a; i++) begin
      @(negedge clk);
      set_in(rf, lead_fp, 1'b0);
      if (i == 1) begin
        exp_src = (!lead_fp) ^ pol;
        if (pol) chk("R3 swapped drive", code(rf), exp_src ? 2 : 1);
        else     chk("R2 lead drive", code(rf), exp_src ? 2 : 1);
      end
      if (i == TWU && a > TWU && !mon_en)
        chk("R5 unlock while pending", mon_out, 0);
      if (i == a) set_in(rf, !lead_fp, 1'b1);
    end
    @(negedge clk);
    set_in(rf, 1'b0, 1'b0);
    set_in(rf, 1'b1, 1'b0);
    chk("R4 closing pulse", code(rf), 3);
    @(negedge clk);
    chk("R4 pulse ends", code(rf), 0);
    repeat (2) @(negedge clk);
    model(rf, a);
    if (!mon_en) chk("R6 lock state", mon_out, exp_lock_all());
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset rf", code(1), 0);
    chk("R1 reset if", code(0), 0);
    chk("R1 reset mon", mon_out, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 after release", mon_out, 0);

    // high band alone, low band in power-save
    pwr_if = 0;
    @(negedge clk);
    chk("R7 ps counts as locked only if other locked", mon_out, 0);
    cmp(1, 1);
    cmp(1, 0);
    chk("R6 not yet locked after two", mon_out, 0);
    cmp(1, -2);
    chk("R6 locked after three", mon_out, 1);
    cmp(1, 6);
    chk("R5 unlocked by large error", mon_out, 0);
    cmp(1, 2); cmp(1, 2); cmp(1, 4); cmp(1, 1); cmp(1, 1);
    chk("R6 run restarted", mon_out, 0);
    cmp(1, -1);
    chk("R6 locked again", mon_out, 1);

    // polarity swap
    pol_rf = 1;
    cmp(1, 2); cmp(1, -3); cmp(1, 0);
    pol_rf = 0;

    // combined flag
    cmp(1, 0); cmp(1, 0); cmp(1, 0);
    @(negedge clk); pwr_if = 1; lk_if = 0; gd_if = 0;
    @(negedge clk);
    chk("R7 powered unlocked loop", mon_out, 0);
    cmp(0, 1); cmp(0, -1); cmp(0, 0);
    chk("R7 both locked", mon_out, 1);
    @(negedge clk); pwr_rf = 0; lk_rf = 0; gd_rf = 0;
    @(negedge clk);
    chk("R7 high band in ps", mon_out, 1);
    chk("R9 outputs quiet", code(1), 0);
    // edges during power-save must leave nothing behind
    fr_rf = 1; @(negedge clk); fr_rf = 0;
    @(negedge clk);
    chk("R9 no drive in ps", code(1), 0);
    pwr_rf = 1;
    @(negedge clk);
    chk("R9 woken loop unlocked", mon_out, 0);
    cmp(1, -2);

    // random comparisons on both loops
    for (int k = 0; k < 40; k++) begin
      bit rf;
      rf = ($urandom_range(1, 0) == 1);
      if (rf) pol_rf = ($urandom_range(1, 0) == 1);
      else    pol_if = ($urandom_range(1, 0) == 1);
      cmp(rf, int'($urandom_range(10, 0)) - 5);
    end

    // monitor selection with both loops in power-save
    @(negedge clk); pwr_rf = 0; pwr_if = 0; mon_en = 1;
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 4; w++) begin
        int pick;
        @(negedge clk);
        mon_sel = 2'(s);
        fr_if = (w == 0); fr_rf = (w == 1); fp_if = (w == 2); fp_rf = (w == 3);
        #1;
        pick = (s == 0) ? 0 : (s == 2) ? 1 : (s == 1) ? 2 : 3;
        chk("R8 monitor select", mon_out, (pick == w) ? 1 : 0);
      end
    end
    @(negedge clk);
    fr_if = 0; fr_rf = 0; fp_if = 0; fp_rf = 0; mon_en = 0;
    #1;
    chk("R7 both in ps", mon_out, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule